// File: doc/BRIEF.md
# Fixed-Point Rounding and Saturation Stage

This stage sits after an arithmetic datapath and narrows a fixed-point result. It removes a fixed number of fractional bits from the low end of the input word and rounds to the nearest value that the kept bits can represent. It then clamps the rounded value into a possibly narrower output word, so that an out-of-range result becomes the nearest representable extreme instead of wrapping. Each input word carries a run-time flag that marks it as two's complement or as unsigned.

The rounding rule is chosen when the design is built, through the `MODE` parameter. The biased rule sends an exact half upward. The unbiased rule sends an exact half to whichever neighbour has a zero least significant bit, which avoids the DC drift that the biased rule builds up over many samples. The two rules disagree only on that exact-half case with an even kept part. The result is registered, so it appears one clock after its input strobe, together with a flag that marks clamped samples.

Top module: `rsat_stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dout`, `sat` and `out_valid` are all zero.
- R2: `out_valid` equals the value `in_valid` had at the preceding rising clock edge, so each result appears exactly one cycle after its input.
- R3: A cycle with `in_valid` low leaves `dout` unchanged and forces `sat` to 0 in the next cycle.
- R4: With `MODE` biased, the kept part (input bits `IN_W-1` down to `DROP_W`) is incremented whenever the dropped field is one half or more, that is, whenever dropped bit `DROP_W-1` is 1.
- R5: With `MODE` even, the kept part is incremented when the dropped field exceeds one half, or when it equals exactly one half (bit `DROP_W-1` set and all lower dropped bits clear) and the kept LSB (input bit `DROP_W`) is 1. An exact half with a kept LSB of 0 truncates.
- R6: With `is_signed`=0 (unsigned), 6 input bits reduced to 4 in even mode give 010111→0110, 001101→0011, 001010→0010 and 001110→0100.
- R7: With `is_signed`=1 (two's complement), 6 input bits reduced to 4 in even mode give 110111→1110, 101101→1011, 110110→1110 and 110010→1100.
- R8: The biased and even modes give identical outputs for every input except an exact-half dropped field with a kept LSB of 0, where the biased result is one greater.
- R9: An unsigned result above 2^OUT_W−1 gives `dout` all ones and `sat`=1.
- R10: A signed result above 2^(OUT_W−1)−1 gives `dout`=0 followed by ones and `sat`=1. A non-negative signed input never gives a negative output.
- R11: A signed result below −2^(OUT_W−1) gives `dout`=1 followed by zeros and `sat`=1.
- R12: A rounded result that fits the output range appears unchanged in `dout`, with `sat`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| is_signed | input | 1 | 1 = two's complement input, 0 = unsigned |
| din | input | IN_W | Wide fixed-point input |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dout | output | OUT_W | Rounded and clamped result |
| sat | output | 1 | High when the registered result was clamped |

## Verification
The properties assume that `is_signed` is sampled together with `din` on the strobe cycle, and that the parameters satisfy `OUT_W` ≤ `IN_W`−`DROP_W` with `DROP_W` ≥ 1. Only under those conditions do the clamp extremes and the sign rule hold. The bench changes inputs only on falling edges and keeps `is_signed` steady for the whole strobe cycle. It instantiates three configurations within those bounds: even and biased with equal kept and output widths, and an even stage whose output is narrower than the kept part so that both clamp directions can be reached. It sweeps every input code in both signedness settings against an integer model.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic {
        RND_BIASED = 1'b0,
        RND_EVEN   = 1'b1
    } round_mode_e;

endpackage

// File: rtl/rs_round_core.sv
module rs_round_core #(
    parameter int                  KEEP_W = 4,
    parameter int                  DROP_W = 2,
    parameter rs_pkg::round_mode_e MODE   = rs_pkg::RND_EVEN
) (
    input  logic [KEEP_W-1:0] kept,
    input  logic [DROP_W-1:0] frac,
    input  logic              is_signed,
    output logic [KEEP_W:0]   rounded
);

    logic half_bit;
    logic below_half;
    logic tie;
    logic bump;
    logic [KEEP_W:0] kept_ext;

    assign half_bit = frac[DROP_W-1];

    generate
        if (DROP_W == 1) begin : g_one_drop
            assign below_half = 1'b0;
        end else begin : g_multi_drop
            assign below_half = |frac[DROP_W-2:0];
        end
    endgenerate

    assign tie = half_bit & ~below_half;

    generate
        if (MODE == rs_pkg::RND_EVEN) begin : g_even
            assign bump = half_bit & ~(tie & ~kept[0]);
        end else begin : g_biased
            assign bump = half_bit;
        end
    endgenerate

    // one extra bit so the increment can never wrap
    assign kept_ext = {is_signed & kept[KEEP_W-1], kept};
    assign rounded  = kept_ext + {{KEEP_W{1'b0}}, bump};

endmodule

// File: rtl/rs_sat_clamp.sv
module rs_sat_clamp #(
    parameter int W_IN  = 5,
    parameter int OUT_W = 4
) (
    input  logic [W_IN-1:0]  val,
    input  logic             is_signed,
    output logic [OUT_W-1:0] res,
    output logic             clamped
);

    localparam int S_TOP = W_IN - OUT_W + 1;
    localparam int U_TOP = W_IN - OUT_W;

    logic [S_TOP-1:0] s_head;
    logic [U_TOP-1:0] u_head;
    logic             s_fits;
    logic             u_fits;

    assign s_head = val[W_IN-1:OUT_W-1];
    assign u_head = val[W_IN-1:OUT_W];
    assign s_fits = (&s_head) | ~(|s_head);
    assign u_fits = ~(|u_head);

    always_comb begin
        res     = val[OUT_W-1:0];
        clamped = 1'b0;
        if (is_signed) begin
            if (!s_fits) begin
                clamped = 1'b1;
                res     = val[W_IN-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                      : {1'b0, {(OUT_W-1){1'b1}}};
            end
        end else if (!u_fits) begin
            clamped = 1'b1;
            res     = {OUT_W{1'b1}};
        end
    end

endmodule

// File: rtl/rsat_stage.sv
module rsat_stage #(
    parameter int                  IN_W   = 6,
    parameter int                  DROP_W = 2,
    parameter int                  OUT_W  = 4,
    parameter rs_pkg::round_mode_e MODE   = rs_pkg::RND_EVEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             is_signed,
    input  logic [IN_W-1:0]  din,
    output logic             out_valid,
    output logic [OUT_W-1:0] dout,
    output logic             sat
);

    localparam int KEEP_W = IN_W - DROP_W;

    typedef struct packed {
        logic             vld;
        logic             sat;
        logic [OUT_W-1:0] data;
    } stage_t;

    stage_t stage_d;
    stage_t stage_q;

    logic [KEEP_W:0]   rounded;
    logic [OUT_W-1:0]  clamp_res;
    logic              clamp_hit;

    rs_round_core #(
        .KEEP_W (KEEP_W),
        .DROP_W (DROP_W),
        .MODE   (MODE)
    ) u_round (
        .kept      (din[IN_W-1:DROP_W]),
        .frac      (din[DROP_W-1:0]),
        .is_signed (is_signed),
        .rounded   (rounded)
    );

    rs_sat_clamp #(
        .W_IN  (KEEP_W + 1),
        .OUT_W (OUT_W)
    ) u_clamp (
        .val       (rounded),
        .is_signed (is_signed),
        .res       (clamp_res),
        .clamped   (clamp_hit)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        stage_d.sat = 1'b0;
        if (in_valid) begin
            stage_d.data = clamp_res;
            stage_d.sat  = clamp_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign dout      = stage_q.data;
    assign sat       = stage_q.sat;

endmodule

// File: rtl/rsat_stage_chk.sv
module rsat_stage_chk #(
    parameter int OUT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             is_signed,
    input logic             din_msb,
    input logic             out_valid,
    input logic [OUT_W-1:0] dout,
    input logic             sat
);

    localparam logic [OUT_W-1:0] S_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] S_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dout) && !sat)); // R3
    AST_UNSIGNED_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_signed) |=> (!sat || (&dout))); // R9
    AST_SIGNED_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_signed) |=> (!sat || dout == S_MAX || dout == S_MIN)); // R11
    AST_POS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_signed && !din_msb) |=> !dout[OUT_W-1]); // R10

endmodule

bind rsat_stage rsat_stage_chk #(
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .is_signed (is_signed),
    .din_msb   (din[IN_W-1]),
    .out_valid (out_valid),
    .dout      (dout),
    .sat       (sat)
);

// File: tb/test_rsat_stage.sv
module test_rsat_stage;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       is_signed = 1'b0;
    logic [7:0] din = '0;

    logic       a_vld, b_vld, c_vld;
    logic [3:0] a_dout, b_dout, c_dout;
    logic       a_sat, b_sat, c_sat;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    // even mode, 6 -> 4
    rsat_stage #(.IN_W(6), .DROP_W(2), .OUT_W(4), .MODE(rs_pkg::RND_EVEN)) i_rsat_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_signed(is_signed),
        .din(din[5:0]), .out_valid(a_vld), .dout(a_dout), .sat(a_sat));

    // biased mode, 6 -> 4
    rsat_stage #(.IN_W(6), .DROP_W(2), .OUT_W(4), .MODE(rs_pkg::RND_BIASED)) i_rsat_stage_biased (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_signed(is_signed),
        .din(din[5:0]), .out_valid(b_vld), .dout(b_dout), .sat(b_sat));

    // even mode, 8 -> 6 kept -> 4 out
    rsat_stage #(.IN_W(8), .DROP_W(2), .OUT_W(4), .MODE(rs_pkg::RND_EVEN)) i_rsat_stage_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_signed(is_signed),
        .din(din), .out_valid(c_vld), .dout(c_dout), .sat(c_sat));

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // independent integer model; returns {sat, dout}
    function automatic int model(int in_w, int dr, int ow, bit even, int raw, bit sgn);
        int v, q, r, half, lo, hi;
        bit s;
        raw  = raw & ((1 << in_w) - 1);
        v    = (sgn && ((raw >> (in_w - 1)) & 1) == 1) ? raw - (1 << in_w) : raw;
        q    = v >>> dr;
        r    = v - q * (1 << dr);
        half = 1 << (dr - 1);
        if (r > half || (r == half && (!even || (q & 1) == 1))) q = q + 1;
        lo = sgn ? -(1 << (ow - 1)) : 0;
        hi = sgn ? (1 << (ow - 1)) - 1 : (1 << ow) - 1;
        s  = 1'b0;
        if (q > hi) begin q = hi; s = 1'b1; end
        if (q < lo) begin q = lo; s = 1'b1; end
        return (int'(s) << ow) | (q & ((1 << ow) - 1));
    endfunction

    task automatic step(logic [7:0] d, logic sg, logic v);
        @(negedge clk);
        din = d; is_signed = sg; in_valid = v;
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 dout in reset", int'(a_dout), 0);
        check("R1 sat/valid in reset", int'({a_sat, a_vld, c_sat, c_vld}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'({a_dout, a_sat, a_vld}), 0);
    endtask

    task automatic test_doc_unsigned();
        step(8'b010111, 1'b0, 1'b1); check("R6 010111", int'(a_dout), 4'b0110);
        check("R2 out_valid after strobe", int'(a_vld), 1);
        step(8'b001101, 1'b0, 1'b1); check("R6 001101", int'(a_dout), 4'b0011);
        step(8'b001010, 1'b0, 1'b1); check("R6 001010", int'(a_dout), 4'b0010);
        check("R5 tie even truncates", int'(a_dout), 4'b0010);
        check("R4 biased tie rounds up", int'(b_dout), 4'b0011);
        step(8'b001110, 1'b0, 1'b1); check("R6 001110", int'(a_dout), 4'b0100);
        check("R5 tie odd rounds up", int'(a_dout), 4'b0100);
    endtask

    task automatic test_doc_signed();
        step(8'b110111, 1'b1, 1'b1); check("R7 110111", int'(a_dout), 4'b1110);
        step(8'b101101, 1'b1, 1'b1); check("R7 101101", int'(a_dout), 4'b1011);
        step(8'b110110, 1'b1, 1'b1); check("R7 110110", int'(a_dout), 4'b1110);
        step(8'b110010, 1'b1, 1'b1); check("R7 110010", int'(a_dout), 4'b1100);
        check("R4 biased signed tie", int'(b_dout), 4'b1101);
    endtask

    task automatic test_clamps();
        step(8'b111110, 1'b0, 1'b1);
        check("R9 unsigned carry clamp", int'({a_sat, a_dout}), 5'b1_1111);
        step(8'b111101, 1'b0, 1'b1);
        check("R12 unsigned max fits", int'({a_sat, a_dout}), 5'b0_1111);
        step(8'b011110, 1'b1, 1'b1);
        check("R10 signed carry clamp", int'({a_sat, a_dout}), 5'b1_0111);
        step(8'b00100000, 1'b1, 1'b1);
        check("R10 narrow positive clamp", int'({c_sat, c_dout}), 5'b1_0111);
        step(8'b11000000, 1'b1, 1'b1);
        check("R11 narrow negative clamp", int'({c_sat, c_dout}), 5'b1_1000);
        step(8'b11100000, 1'b1, 1'b1);
        check("R12 narrow min fits", int'({c_sat, c_dout}), 5'b0_1000);
        step(8'b01000000, 1'b0, 1'b1);
        check("R9 narrow unsigned clamp", int'({c_sat, c_dout}), 5'b1_1111);
    endtask

    task automatic test_idle_hold();
        step(8'b11000000, 1'b1, 1'b1);
        check("R11 before idle", int'({c_sat, c_dout}), 5'b1_1000);
        step(8'b00010101, 1'b0, 1'b0);
        check("R2 out_valid low when idle", int'({a_vld, c_vld}), 0);
        check("R3 idle holds data, clears sat", int'({c_sat, c_dout}), 5'b0_1000);
        step(8'b00000000, 1'b1, 1'b0);
        check("R3 second idle cycle", int'({c_sat, c_dout}), 5'b0_1000);
    endtask

    task automatic test_sweep();
        for (int sg = 0; sg < 2; sg++) begin
            for (int d = 0; d < 256; d++) begin
                int ea, eb, ec;
                step(8'(d), 1'(sg), 1'b1);
                ea = model(6, 2, 4, 1'b1, d, 1'(sg));
                eb = model(6, 2, 4, 1'b0, d, 1'(sg));
                ec = model(8, 2, 4, 1'b1, d, 1'(sg));
                check("R5/R12 even sweep", int'({a_sat, a_dout}), ea);
                check("R4/R8 biased sweep", int'({b_sat, b_dout}), eb);
                check("R9/R10/R11 narrow sweep", int'({c_sat, c_dout}), ec);
            end
        end
    endtask

    initial begin
        test_reset();
        test_doc_unsigned();
        test_doc_signed();
        test_clamps();
        test_idle_hold();
        test_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule